// File: doc/BRIEF.md
# Flash Row Write Controller

This block collects program-memory words in a bank of write latches and then commits a whole row to a flash array in one step. A processor-side register interface supplies a word address, a high and a low data byte, a mode bit that picks latch loading or row programming, and a write-start strobe. Each accepted strobe passes through two setup cycles, during which the processor is expected to run no-operation instructions. The addressed latch is then written.

In latch-load mode the operation ends as soon as the latch is written, and the processor never stalls. In row-program mode, the final word goes into its latch. Then `stall` holds the processor for a programmable number of clock cycles while the row is programmed. Clocks keep running during this time. At the end, a one-cycle request carries the row number and all latch contents to a behavioural flash array. The latches then return to the erased value. Execution resumes at the third instruction after the one that started the write.

Top module: `flash_row_writer`

## Requirements
- R1: During and right after reset, `stall`, `wr_busy`, `wr_err` and `prog_req` are 0, and every latch holds 14'h3FFF.
- R2: A word is built with `data_hi` as bits 13:8 and `data_lo` as bits 7:0. It is stored in the latch picked by `addr[4:0]`.
- R3: With `latch_only` = 1, a strobe writes its latch and never raises `stall`. `wr_busy` is high for exactly two cycles.
- R4: With `latch_only` = 0, a strobe writes its word and then programs the row `addr[ADDR_W-1:5]`. `prog_data[i*14 +: 14]` carries latch i.
- R5: In row-program mode, `stall` rises in the third cycle after the strobe is sampled, following two setup cycles.
- R6: `stall` stays high for exactly PROG_CYCLES cycles.
- R7: `prog_req` is high for one cycle, the first cycle after `stall` falls. `wr_busy` goes low in that same cycle.
- R8: After a row program, all latches read 14'h3FFF until they are written again.
- R9: A strobe during programming is ignored and sets `wr_err`, which stays set until reset. A strobe during setup is ignored without an error.
- R10: `wr_busy` (the write-start bit) is set in the cycle after a strobe is accepted. It clears when the operation ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Write-start strobe |
| addr | input | ADDR_W | Word address: row in the upper bits, latch in bits 4:0 |
| data_hi | input | 6 | Upper six bits of the word |
| data_lo | input | 8 | Lower eight bits of the word |
| latch_only | input | 1 | 1 = load latch only, 0 = program row |
| wr_busy | output | 1 | Write-start bit, self-clearing |
| stall | output | 1 | Holds the processor during row programming |
| wr_err | output | 1 | Sticky error: strobe seen during programming |
| prog_req | output | 1 | One-cycle row-program request |
| prog_row | output | ADDR_W-5 | Row to program |
| prog_data | output | 448 | All latch words, latch i at bits i*14 +: 14 |

## Verification
A strobe is sampled at edge E0, and `wr_busy` is due in the following cycle. The latch is written at E0+2. In row mode, `stall` is high from E0+2 up to E0+2+PROG_CYCLES. `prog_req`, `prog_row` and `prog_data` are valid for the one cycle after that. The bench model advances on the same rising edges as the design and compares every output at the falling edge. Each result is therefore checked in exactly the cycle it is due, neither earlier nor later. Latch contents are only visible through `prog_data`, so latch loads and the refill to the erased value are checked on the next row program.

// File: rtl/flash_row_writer.sv
module flash_row_writer #(
  parameter int ADDR_W      = 11,
  parameter int LATCHES     = 32,
  parameter int HI_W        = 6,
  parameter int LO_W        = 8,
  parameter int PROG_CYCLES = 64000
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_start,
  input  logic [ADDR_W-1:0]                     addr,
  input  logic [HI_W-1:0]                       data_hi,
  input  logic [LO_W-1:0]                       data_lo,
  input  logic                                  latch_only,
  output logic                                  wr_busy,
  output logic                                  stall,
  output logic                                  wr_err,
  output logic                                  prog_req,
  output logic [ADDR_W-$clog2(LATCHES)-1:0]     prog_row,
  output logic [LATCHES*(HI_W+LO_W)-1:0]        prog_data
);
  localparam int WORD_W = HI_W + LO_W;
  localparam int IDX_W  = $clog2(LATCHES);
  localparam int CNT_W  = $clog2(PROG_CYCLES + 1);

  typedef enum logic [1:0] {IDLE, SU1, SU2, PROG} st_t;
  st_t st;

  logic [WORD_W-1:0] lat [LATCHES];
  logic [ADDR_W-1:0] a_q;
  logic [WORD_W-1:0] w_q;
  logic              lo_q;
  logic [CNT_W-1:0]  cnt;
  logic [LATCHES*WORD_W-1:0] flat;

  for (genvar g = 0; g < LATCHES; g++) begin : g_flat
    assign flat[g*WORD_W +: WORD_W] = lat[g];
  end

  assign wr_busy = (st != IDLE);
  assign stall   = (st == PROG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      a_q       <= '0;
      w_q       <= '0;
      lo_q      <= 1'b0;
      cnt       <= '0;
      wr_err    <= 1'b0;
      prog_req  <= 1'b0;
      prog_row  <= '0;
      prog_data <= '0;
      for (int i = 0; i < LATCHES; i++) lat[i] <= '1;
    end else begin
      prog_req <= 1'b0;
      case (st)
        IDLE: if (wr_start) begin
          a_q  <= addr;
          w_q  <= {data_hi, data_lo};
          lo_q <= latch_only;
          st   <= SU1;
        end
        SU1: st <= SU2;
        SU2: begin
          lat[a_q[IDX_W-1:0]] <= w_q;
          if (lo_q) st <= IDLE;
          else begin
            st  <= PROG;
            cnt <= CNT_W'(PROG_CYCLES - 1);
          end
        end
        PROG: begin
          if (wr_start) wr_err <= 1'b1;
          if (cnt == '0) begin
            st        <= IDLE;
            prog_req  <= 1'b1;
            prog_row  <= a_q[ADDR_W-1:IDX_W];
            prog_data <= flat;
            for (int i = 0; i < LATCHES; i++) lat[i] <= '1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module flash_row_writer_chk #(
  parameter int PROG_CYCLES = 64000
) (
  input logic clk,
  input logic rst_n,
  input logic wr_busy,
  input logic stall,
  input logic wr_err,
  input logic prog_req
);
  int len;
  always_ff @(posedge clk) begin
    if (!rst_n)     len <= 0;
    else if (stall) len <= len + 1;
    else            len <= 0;
  end

  // R5
  stall_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> ($past(wr_busy, 1) && $past(wr_busy, 2)));
  // R6
  stall_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> (len == PROG_CYCLES));
  // R7
  req_follows_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> (prog_req && !wr_busy));
  // R7
  req_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);
  // R10
  stall_implies_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> wr_busy);
endmodule

bind flash_row_writer flash_row_writer_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_busy(wr_busy), .stall(stall),
  .wr_err(wr_err), .prog_req(prog_req)
);

// File: tb/flash_row_writer_tb.sv
`timescale 1ns/1ps
module flash_row_writer_tb;
  localparam int ADDR_W = 11;
  localparam int NL     = 32;
  localparam int WW     = 14;
  localparam int PC     = 20;
  localparam int RW     = ADDR_W - 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_start = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [5:0] data_hi = '0;
  logic [7:0] data_lo = '0;
  logic latch_only = 1'b0;
  logic wr_busy, stall, wr_err, prog_req;
  logic [RW-1:0] prog_row;
  logic [NL*WW-1:0] prog_data;

  always #2.5 clk = ~clk;

  flash_row_writer #(.ADDR_W(ADDR_W), .LATCHES(NL), .HI_W(6), .LO_W(8), .PROG_CYCLES(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .addr(addr), .data_hi(data_hi),
    .data_lo(data_lo), .latch_only(latch_only), .wr_busy(wr_busy), .stall(stall),
    .wr_err(wr_err), .prog_req(prog_req), .prog_row(prog_row), .prog_data(prog_data)
  );

  int compared = 0, mismatched = 0;
  string tag = "R1";
  bit done = 0;

  // reference model
  int m_lat [NL];
  int m_phase, m_left, m_addr, m_word, m_lonly, m_row;
  bit m_busy, m_err, m_req;
  logic [NL*WW-1:0] m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_lat[i]) m_lat[i] = 16'h3FFF;
      m_phase = 0; m_left = 0; m_busy = 0; m_err = 0; m_req = 0;
      m_row = 0; m_data = '0;
    end else begin
      m_req = 0;
      case (m_phase)
        0: if (wr_start) begin
             m_addr = addr; m_word = data_hi * 256 + data_lo; m_lonly = latch_only;
             m_phase = 1; m_busy = 1;
           end
        1: m_phase = 2;
        2: begin
             m_lat[m_addr % 32] = m_word;
             if (m_lonly != 0) begin m_phase = 0; m_busy = 0; end
             else begin m_phase = 3; m_left = PC; end
           end
        default: begin
             if (wr_start) m_err = 1;
             m_left = m_left - 1;
             if (m_left == 0) begin
               m_req = 1; m_row = m_addr / 32;
               foreach (m_lat[i]) m_data[i*WW +: WW] = WW'(m_lat[i]);
               foreach (m_lat[i]) m_lat[i] = 16'h3FFF;
               m_phase = 0; m_busy = 0;
             end
           end
      endcase
    end
  end

  task automatic chk(input string what, input logic [NL*WW-1:0] act, input logic [NL*WW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("stall R6", NL*WW'(stall), NL*WW'(m_phase == 3));
      chk("wr_busy R10", NL*WW'(wr_busy), NL*WW'(m_busy));
      chk("wr_err R9", NL*WW'(wr_err), NL*WW'(m_err));
      chk("prog_req R7", NL*WW'(prog_req), NL*WW'(m_req));
      if (m_req) begin
        chk("prog_row R4", NL*WW'(prog_row), NL*WW'(m_row));
        chk("prog_data", prog_data, m_data);
      end
    end
  end

  task automatic strobe(input int a, input int hi, input int lo, input bit lonly);
    @(negedge clk);
    addr = ADDR_W'(a); data_hi = 6'(hi); data_lo = 8'(lo); latch_only = lonly; wr_start = 1'b1;
    @(negedge clk);
    wr_start = 1'b0;
  endtask

  task automatic finish_up;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    compared++; mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";  // reset state
    chk("reset stall", NL*WW'(stall), '0);
    chk("reset busy", NL*WW'(wr_busy), '0);
    chk("reset err", NL*WW'(wr_err), '0);
    chk("reset req", NL*WW'(prog_req), '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 / R3: latch loads with distinct patterns; row bits ignored for latch index
    tag = "R3";
    strobe(11'h000, 6'h2A, 8'h55, 1); repeat (3) @(negedge clk);
    strobe(11'h7E1, 6'h01, 8'h80, 1); repeat (3) @(negedge clk);
    strobe(11'h01E, 6'h3F, 8'h00, 1); repeat (3) @(negedge clk);
    tag = "R2";
    strobe(11'h125, 6'h00, 8'hFF, 1); repeat (3) @(negedge clk);

    // R4 / R5 / R6 / R7: row program with final word in latch 31
    tag = "R4";
    strobe(11'h0DF, 6'h15, 8'hA3, 0); repeat (PC + 6) @(negedge clk);

    // R8: latches refilled, only final word differs
    tag = "R8";
    strobe(11'h3E7, 6'h11, 8'h22, 0); repeat (PC + 6) @(negedge clk);

    // R9: strobe during setup ignored, strobe during programming ignored and flagged
    tag = "R9";
    strobe(11'h040, 6'h05, 8'h06, 0);
    strobe(11'h041, 6'h07, 8'h08, 1);   // lands in setup: ignored
    repeat (4) @(negedge clk);
    strobe(11'h0FF, 6'h3F, 8'h3F, 1);   // during programming
    repeat (PC + 6) @(negedge clk);
    strobe(11'h060, 6'h09, 8'h0A, 0); repeat (PC + 6) @(negedge clk);

    finish_up();
  end
endmodule